// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block collects interrupt events from a transmit/receive datapath and presents them to a host through a small register port. Events arrive as single-cycle pulses. Each pulse sets a sticky status bit, either directly in the primary status word or in one of five secondary status words that keep per-queue and per-cause detail. Several primary bits are summaries: each one is the OR of a group of secondary bits after the secondary mask. A summary bit therefore stays up while any of its secondary sources is still set and unmasked.

The host clears status by writing ones. Only the bits written as one are cleared. The summary positions in the primary word cannot be cleared from the primary address. They fall only when the host clears their secondary sources, so an event on one queue cannot be lost while the host handles another queue. A primary mask, the per-register secondary masks and a global enable decide whether the single interrupt line is driven. A pending register reports the same condition to software.

Top module: `irq_agg`

## Requirements
- R1: After reset every status, mask and enable register reads zero, `irq` is low and `bus_rdata` is zero.
- R2: A pulse on `ev_pri[i]` sets primary bit i (i < ND). Writing the primary address (0) clears exactly the direct bits written as one.
- R3: A pulse on a secondary event input sets the matching bit of that secondary status word (addresses 4 to 8). Writing ones clears only those bits, and events that arrive later stay latched.
- R4: Primary bit ND+0 is the OR of the masked bits of secondary word 0 (per-queue done in [NQ-1:0], per-queue descriptor in [2NQ-1:NQ]). Primary bit ND+1 is the OR of the masked bits of secondary word 1 (per-queue error and per-queue end-of-list).
- R5: In secondary word 2, bits [NQ-1:0] are per-queue underrun, [NQ+2:NQ] are bus errors (abort, system, parity) and [NQ+NB+2:NQ+3] are beacon/timing causes. Their masked ORs drive primary bits ND+2, ND+3 and ND+4 respectively.
- R6: Primary bit ND+5 is the masked OR of secondary word 3 bits [NQ-1:0] (rate overrun), ND+6 that of bits [2NQ-1:NQ] (rate underrun), and ND+7 that of secondary word 4 (per-queue trigger).
- R7: Writing ones to summary positions of the primary address has no effect. A summary bit falls only after its secondary sources are cleared or masked.
- R8: When an event pulse arrives in the same cycle as a write-one-to-clear of the same bit, the bit stays set.
- R9: `irq` rises one cycle after the global enable (address 2, bit 0) is set while any primary bit ANDed with the primary mask (address 1) is nonzero. `irq` is low whenever the enable was clear in the previous cycle.
- R10: The pending register (address 3) reads 1 exactly when the enable is set and some masked primary bit is set, and reads 0 otherwise.
- R11: The secondary masks (addresses 9 to 13) gate only the contribution to the summary bits. Secondary status bits latch regardless of the masks.
- R12: Address 11 writes only the bus-error and beacon fields of secondary mask 2. Address 14 writes only its per-queue underrun field. Reading address 11 returns the whole mask.
- R13: Read data appears on `bus_rdata` in the cycle after `bus_rd`, zero-extended. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| ev_pri | input | ND | Direct primary event pulses |
| ev_sec0 | input | 2*NQ | Secondary word 0 event pulses |
| ev_sec1 | input | 2*NQ | Secondary word 1 event pulses |
| ev_sec2 | input | NQ+3+NB | Secondary word 2 event pulses |
| ev_sec3 | input | 2*NQ | Secondary word 3 event pulses |
| ev_sec4 | input | NQ | Secondary word 4 event pulses |
| irq | output | 1 | Registered interrupt line |

## Verification
The embedded assertions watch, on every cycle, that a status bit receiving a pulse is set in the next cycle even during a clear, that set bits not written as one are kept, that a summary bit only falls after a write to its secondary status or mask, that the interrupt stays low after a cycle with the enable clear, and that each half of the split mask stays untouched by writes to the other half. The exact bit mapping from each secondary field to its summary position, the independence of the status latch from the masks, the pending read value and the read latency can only be shown by the directed scenarios.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W  = 4;
  localparam int N_BUSERR = 3;
  localparam int N_SUM    = 8;

  // summary positions above the direct bits
  localparam int SUM_TXDONE = 0;
  localparam int SUM_TXFAIL = 1;
  localparam int SUM_URUN   = 2;
  localparam int SUM_HOST   = 3;
  localparam int SUM_BCN    = 4;
  localparam int SUM_RATEO  = 5;
  localparam int SUM_RATEU  = 6;
  localparam int SUM_TRIG   = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_PRI_ST  = 4'd0,
    A_PRI_MSK = 4'd1,
    A_GLB_EN  = 4'd2,
    A_PEND    = 4'd3,
    A_SEC0    = 4'd4,
    A_SEC1    = 4'd5,
    A_SEC2    = 4'd6,
    A_SEC3    = 4'd7,
    A_SEC4    = 4'd8,
    A_SMSK0   = 4'd9,
    A_SMSK1   = 4'd10,
    A_SMSK2   = 4'd11,
    A_SMSK3   = 4'd12,
    A_SMSK4   = 4'd13,
    A_SMSK2_Q = 4'd14
  } reg_addr_e;
endpackage

// File: rtl/irq_w1c_reg.sv
module irq_w1c_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] clr,
  output logic [W-1:0] st
);
  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= (st & ~clr) | ev;
  end

  AST_W1C_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> ((st & $past(ev)) == $past(ev))); // R8

  AST_W1C_KEEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st & ($past(st) & ~$past(clr))) == ($past(st) & ~$past(clr)))); // R3
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~we) | (d & we);
  end
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gen,
  input  logic [PW-1:0] prim,
  input  logic [PW-1:0] pmask,
  output logic          hit,
  output logic          irq
);
  assign hit = gen & (|(prim & pmask));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= hit;
  end

  AST_GEN_GATES_IRQ: assert property (@(posedge clk) disable iff (rst)
    !gen |=> !irq); // R9
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NQ = 4,
  parameter int ND = 4,
  parameter int NB = 5,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [ND-1:0]        ev_pri,
  input  logic [2*NQ-1:0]      ev_sec0,
  input  logic [2*NQ-1:0]      ev_sec1,
  input  logic [NQ+3+NB-1:0]   ev_sec2,
  input  logic [2*NQ-1:0]      ev_sec3,
  input  logic [NQ-1:0]        ev_sec4,
  output logic                 irq
);
  localparam int WQ2 = 2 * NQ;
  localparam int W2  = NQ + N_BUSERR + NB;
  localparam int PW  = ND + N_SUM;

  // write decode
  logic [ND-1:0]  clr_pri;
  logic [WQ2-1:0] clr0, clr1, clr3;
  logic [W2-1:0]  clr2;
  logic [NQ-1:0]  clr4;
  logic [PW-1:0]  we_pm;
  logic [WQ2-1:0] we_sm0, we_sm1, we_sm3;
  logic [W2-1:0]  we_sm2;
  logic [NQ-1:0]  we_sm4;
  logic           we_gen;

  always_comb begin
    clr_pri = '0; clr0 = '0; clr1 = '0; clr2 = '0; clr3 = '0; clr4 = '0;
    we_pm = '0; we_sm0 = '0; we_sm1 = '0; we_sm2 = '0; we_sm3 = '0; we_sm4 = '0;
    we_gen = 1'b0;
    if (bus_wr) begin
      case (bus_addr)
        A_PRI_ST:  clr_pri = bus_wdata[ND-1:0];
        A_PRI_MSK: we_pm   = '1;
        A_GLB_EN:  we_gen  = 1'b1;
        A_SEC0:    clr0    = bus_wdata[WQ2-1:0];
        A_SEC1:    clr1    = bus_wdata[WQ2-1:0];
        A_SEC2:    clr2    = bus_wdata[W2-1:0];
        A_SEC3:    clr3    = bus_wdata[WQ2-1:0];
        A_SEC4:    clr4    = bus_wdata[NQ-1:0];
        A_SMSK0:   we_sm0  = '1;
        A_SMSK1:   we_sm1  = '1;
        A_SMSK2:   we_sm2[W2-1:NQ] = '1;
        A_SMSK3:   we_sm3  = '1;
        A_SMSK4:   we_sm4  = '1;
        A_SMSK2_Q: we_sm2[NQ-1:0]  = '1;
        default: ;
      endcase
    end
  end

  // status words
  logic [ND-1:0]  pri_st;
  logic [WQ2-1:0] sst0, sst1, sst3;
  logic [W2-1:0]  sst2;
  logic [NQ-1:0]  sst4;

  irq_w1c_reg #(.W(ND))  u_st_pri (.clk(clk), .rst(rst), .ev(ev_pri),  .clr(clr_pri), .st(pri_st));
  irq_w1c_reg #(.W(WQ2)) u_st_s0  (.clk(clk), .rst(rst), .ev(ev_sec0), .clr(clr0),    .st(sst0));
  irq_w1c_reg #(.W(WQ2)) u_st_s1  (.clk(clk), .rst(rst), .ev(ev_sec1), .clr(clr1),    .st(sst1));
  irq_w1c_reg #(.W(W2))  u_st_s2  (.clk(clk), .rst(rst), .ev(ev_sec2), .clr(clr2),    .st(sst2));
  irq_w1c_reg #(.W(WQ2)) u_st_s3  (.clk(clk), .rst(rst), .ev(ev_sec3), .clr(clr3),    .st(sst3));
  irq_w1c_reg #(.W(NQ))  u_st_s4  (.clk(clk), .rst(rst), .ev(ev_sec4), .clr(clr4),    .st(sst4));

  // masks and enable
  logic [PW-1:0]  pmask;
  logic [WQ2-1:0] smk0, smk1, smk3;
  logic [W2-1:0]  smk2;
  logic [NQ-1:0]  smk4;
  logic           gen;

  irq_mask_reg #(.W(PW))  u_mk_pri (.clk(clk), .rst(rst), .we(we_pm),  .d(bus_wdata[PW-1:0]),  .q(pmask));
  irq_mask_reg #(.W(WQ2)) u_mk_s0  (.clk(clk), .rst(rst), .we(we_sm0), .d(bus_wdata[WQ2-1:0]), .q(smk0));
  irq_mask_reg #(.W(WQ2)) u_mk_s1  (.clk(clk), .rst(rst), .we(we_sm1), .d(bus_wdata[WQ2-1:0]), .q(smk1));
  irq_mask_reg #(.W(W2))  u_mk_s2  (.clk(clk), .rst(rst), .we(we_sm2), .d(bus_wdata[W2-1:0]),  .q(smk2));
  irq_mask_reg #(.W(WQ2)) u_mk_s3  (.clk(clk), .rst(rst), .we(we_sm3), .d(bus_wdata[WQ2-1:0]), .q(smk3));
  irq_mask_reg #(.W(NQ))  u_mk_s4  (.clk(clk), .rst(rst), .we(we_sm4), .d(bus_wdata[NQ-1:0]),  .q(smk4));
  irq_mask_reg #(.W(1))   u_mk_gen (.clk(clk), .rst(rst), .we(we_gen), .d(bus_wdata[0]),       .q(gen));

  // summary reduction
  logic [WQ2-1:0] m0, m1, m3;
  logic [W2-1:0]  m2;
  logic [NQ-1:0]  m4;
  logic [N_SUM-1:0] summ;
  logic [PW-1:0]  prim;

  always_comb begin
    m0 = sst0 & smk0;
    m1 = sst1 & smk1;
    m2 = sst2 & smk2;
    m3 = sst3 & smk3;
    m4 = sst4 & smk4;
    summ[SUM_TXDONE] = |m0;
    summ[SUM_TXFAIL] = |m1;
    summ[SUM_URUN]   = |m2[NQ-1:0];
    summ[SUM_HOST]   = |m2[NQ+N_BUSERR-1:NQ];
    summ[SUM_BCN]    = |m2[W2-1:NQ+N_BUSERR];
    summ[SUM_RATEO]  = |m3[NQ-1:0];
    summ[SUM_RATEU]  = |m3[WQ2-1:NQ];
    summ[SUM_TRIG]   = |m4;
    prim = {summ, pri_st};
  end

  logic hit;
  irq_line #(.PW(PW)) u_line (
    .clk(clk), .rst(rst), .gen(gen), .prim(prim), .pmask(pmask), .hit(hit), .irq(irq)
  );

  // read port
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_PRI_ST:  rd_mux[PW-1:0]  = prim;
      A_PRI_MSK: rd_mux[PW-1:0]  = pmask;
      A_GLB_EN:  rd_mux[0]       = gen;
      A_PEND:    rd_mux[0]       = hit;
      A_SEC0:    rd_mux[WQ2-1:0] = sst0;
      A_SEC1:    rd_mux[WQ2-1:0] = sst1;
      A_SEC2:    rd_mux[W2-1:0]  = sst2;
      A_SEC3:    rd_mux[WQ2-1:0] = sst3;
      A_SEC4:    rd_mux[NQ-1:0]  = sst4;
      A_SMSK0:   rd_mux[WQ2-1:0] = smk0;
      A_SMSK1:   rd_mux[WQ2-1:0] = smk1;
      A_SMSK2:   rd_mux[W2-1:0]  = smk2;
      A_SMSK3:   rd_mux[WQ2-1:0] = smk3;
      A_SMSK4:   rd_mux[NQ-1:0]  = smk4;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_SUM_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(prim[ND+SUM_TXDONE]) |->
      $past(bus_wr && (bus_addr == A_SEC0 || bus_addr == A_SMSK0))); // R7

  AST_SMSK2_SPLIT_HI: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == A_SMSK2_Q) |-> $stable(smk2[W2-1:NQ])); // R12

  AST_SMSK2_SPLIT_LO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == A_SMSK2) |-> $stable(smk2[NQ-1:0])); // R12
endmodule

// File: tb/test_irq_agg.sv
module test_irq_agg;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  ev_pri;
  logic [7:0]  ev_sec0, ev_sec1, ev_sec3;
  logic [11:0] ev_sec2;
  logic [3:0]  ev_sec4;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_agg i_irq_agg (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pri(ev_pri), .ev_sec0(ev_sec0),
    .ev_sec1(ev_sec1), .ev_sec2(ev_sec2), .ev_sec3(ev_sec3), .ev_sec4(ev_sec4), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    ev_pri = 0; ev_sec0 = 0; ev_sec1 = 0; ev_sec2 = 0; ev_sec3 = 0; ev_sec4 = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); idle();
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input int r, input logic [11:0] b);
    @(negedge clk);
    case (r)
      0: ev_sec0 = b[7:0];
      1: ev_sec1 = b[7:0];
      2: ev_sec2 = b;
      3: ev_sec3 = b[7:0];
      4: ev_sec4 = b[3:0];
      default: ev_pri = b[3:0];
    endcase
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    rd_chk("R1 pri", 0, 0); rd_chk("R1 pmask", 1, 0); rd_chk("R1 gen", 2, 0);
    rd_chk("R1 smask2", 11, 0); rd_chk("R1 sec2", 6, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_direct();
    pulse(9, 12'h5);
    rd_chk("R2 latch", 0, 32'h005);
    wr(0, 32'h001); rd_chk("R2 partial clear", 0, 32'h004);
    wr(0, 32'h004); rd_chk("R2 clear", 0, 32'h000);
  endtask

  task automatic t_sec0();
    wr(9, 32'hFF);
    pulse(0, 12'h042);
    rd_chk("R3 sec0 latch", 4, 32'h42);
    rd_chk("R4 txdone summary", 0, 32'h010);
    wr(0, 32'hFF0); rd_chk("R7 summary not clearable", 0, 32'h010);
    wr(4, 32'h02); rd_chk("R3 sec0 partial", 4, 32'h40);
    rd_chk("R7 summary holds", 0, 32'h010);
    wr(4, 32'h40); rd_chk("R7 summary falls", 0, 32'h000);
    wr(9, 32'h00); pulse(0, 12'h001);
    rd_chk("R11 latch while masked", 4, 32'h01);
    rd_chk("R11 no summary while masked", 0, 32'h000);
    wr(9, 32'h01); rd_chk("R11 summary after unmask", 0, 32'h010);
    wr(4, 32'h01);
  endtask

  task automatic t_sec1();
    wr(10, 32'hFF); pulse(1, 12'h080);
    rd_chk("R4 txfail summary", 0, 32'h020);
    wr(5, 32'h80); rd_chk("R4 txfail cleared", 0, 32'h000);
  endtask

  task automatic t_sec2();
    wr(11, 32'hFFF); rd_chk("R12 upper only", 11, 32'hFF0);
    wr(14, 32'hFFF); rd_chk("R12 queue field", 11, 32'hFFF);
    wr(14, 32'h000); rd_chk("R12 queue clear keeps upper", 11, 32'hFF0);
    pulse(2, 12'h020); rd_chk("R5 host error", 0, 32'h080);
    pulse(2, 12'h001); rd_chk("R5 underrun masked", 0, 32'h080);
    rd_chk("R5 sec2 status", 6, 32'h021);
    wr(14, 32'h001); rd_chk("R5 underrun summary", 0, 32'h0C0);
    pulse(2, 12'h400); rd_chk("R5 beacon summary", 0, 32'h1C0);
    wr(6, 32'hFFF); rd_chk("R5 all cleared", 0, 32'h000);
  endtask

  task automatic t_sec34();
    wr(12, 32'hFF); wr(13, 32'hF);
    pulse(3, 12'h004); rd_chk("R6 rate overrun", 0, 32'h200);
    pulse(3, 12'h040); rd_chk("R6 rate underrun", 0, 32'h600);
    pulse(4, 12'h008); rd_chk("R6 trigger", 0, 32'hE00);
    wr(7, 32'h04); rd_chk("R6 overrun cleared only", 0, 32'hC00);
    wr(7, 32'hFF); wr(8, 32'hF); rd_chk("R6 cleared", 0, 32'h000);
  endtask

  task automatic t_collide();
    pulse(9, 12'h2);
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 32'h2; ev_pri = 4'h2;
    @(negedge clk); idle();
    rd_chk("R8 direct set wins", 0, 32'h002);
    pulse(1, 12'h001);
    @(negedge clk); bus_wr = 1; bus_addr = 5; bus_wdata = 32'h1; ev_sec1 = 8'h01;
    @(negedge clk); idle();
    rd_chk("R8 secondary set wins", 5, 32'h01);
    wr(5, 32'h01); rd_chk("R3 secondary clear", 5, 32'h00);
  endtask

  task automatic t_irq();
    // direct bit 1 still set from t_collide
    wr(1, 32'h002);
    @(negedge clk); check("R9 no irq while disabled", {31'd0, irq}, 0);
    rd_chk("R10 pending disabled", 3, 0);
    wr(2, 32'h1);
    @(negedge clk); check("R9 irq asserted", {31'd0, irq}, 1);
    rd_chk("R10 pending set", 3, 1);
    wr(2, 32'h0);
    @(negedge clk); check("R9 irq gated off", {31'd0, irq}, 0);
    wr(2, 32'h1); wr(1, 32'h001);
    @(negedge clk); check("R9 masked source", {31'd0, irq}, 0);
    rd_chk("R10 pending masked", 3, 0);
    wr(1, 32'h002); wr(0, 32'h002);
    @(negedge clk); check("R9 irq after clear", {31'd0, irq}, 0);
    rd_chk("R10 pending after clear", 3, 0);
  endtask

  task automatic t_misc();
    rd_chk("R13 unmapped", 15, 0);
    rd_chk("R13 zero-extended mask", 1, 32'h002);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_direct();
    t_sec0();
    t_sec1();
    t_sec2();
    t_sec34();
    t_collide();
    t_irq();
    t_misc();
    finish_run();
  end
endmodule